// File: doc/BRIEF.md
# Control Endpoint Transmit Buffer Packetizer

This block is the 128-byte transmit store of a USB control endpoint. Software fills it through a data port. Each write stores either one byte or a 16-bit little-endian word, and an internal write offset steps by the number of bytes stored. A ready strobe then hands the whole buffer to the serial transmit engine. From that point the buffer belongs to the engine until it has been drained successfully. While the buffer is owned by the engine, further software writes and strobes are discarded.

The engine sees one packet at a time. It reads the packet length, pulls bytes one at a time with a pop strobe, and then reports either success or failure. In single-packet mode, everything loaded goes out as one packet. In continuous mode, the loaded set is cut into packets of the selected maximum size (8, 16, 32 or 64 bytes), and the last packet is short when the count is not a multiple of that size. A failure rewinds the engine to the first byte of the current packet so that the packet can be re-sent. A strobe given with nothing loaded produces a zero-length packet.

Top module: `ep_ctl_txbuf`

## Requirements
- R1: After reset, `inRdy` is 0 and `pktLen` is 0.
- R2: A write with `cpuWordMode`=0 stores `cpuWrData[7:0]` at the write offset and advances the offset by 1. A write with `cpuWordMode`=1 stores `cpuWrData[7:0]` at the offset and `cpuWrData[15:8]` at the offset plus 1, and advances the offset by 2.
- R3: `cpuSetRdy` while `inRdy`=0 sets `inRdy` on the next clock edge.
- R4: While `inRdy`=1, `cpuWrEn` and `cpuSetRdy` have no effect on stored data, on the byte count or on `pktLen`. Only `pktDone` clears `inRdy`.
- R5: With `contMode`=0, `pktLen` equals the whole loaded count, and one `pktDone` clears `inRdy`.
- R6: With `contMode`=1, `pktLen` is the smaller of the unsent byte count and the maximum packet size. The maximum packet size is 8 shifted left by `maxPktSel` (0→8, 1→16, 2→32, 3→64).
- R7: With `contMode`=1, `pktDone` on a packet that is not the last one moves to the next packet and keeps `inRdy` at 1. `inRdy` clears only on `pktDone` of the last packet. A count that is an exact multiple of the packet size ends with a full-size packet.
- R8: `cpuSetRdy` with no bytes loaded gives `pktLen`=0, and one `pktDone` clears `inRdy`.
- R9: `pktFail` while `inRdy`=1 returns `txData` to the first byte of the current packet and leaves `pktLen` and `inRdy` unchanged. If `pktFail` and `pktDone` occur in the same cycle, `pktFail` wins.
- R10: When `inRdy` clears, the write offset and the byte count return to 0, so the next load starts at byte 0 and `pktLen` reads 0.
- R11: Bytes that would land at offset 128 or above are dropped, and the count saturates at 128.
- R12: `txData` shows the byte at the read position of the current packet. `txPop` advances that position by one, and only within the current packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Software data write strobe |
| cpuWordMode | input | 1 | 1 = 16-bit write, 0 = byte write |
| cpuWrData | input | 16 | Write data, low byte stored first |
| cpuSetRdy | input | 1 | Hand the loaded buffer to the engine |
| contMode | input | 1 | 1 = split the set into max-size packets |
| maxPktSel | input | 2 | Maximum packet size select (8 << value) |
| inRdy | output | 1 | Buffer owned by the engine; a packet is offered |
| pktLen | output | 8 | Length of the offered packet |
| txData | output | 8 | Byte at the current read position |
| txPop | input | 1 | Engine consumed `txData` |
| pktDone | input | 1 | Current packet delivered successfully |
| pktFail | input | 1 | Current packet failed or was refused; re-send it |

## Verification
The hardest situations to reach are in the middle of a continuous-mode set: a failure that arrives partway through a packet that is not the first, and a set whose length exceeds the buffer. The stimulus pops only part of the second packet before raising failure, then checks that the very next byte offered is the first byte of that packet. A 140-byte load is written as words, so the last word lands exactly on the buffer boundary and the extra bytes fall away. It is then drained as two 64-byte packets.

// File: rtl/ep_ctl_txbuf_pkg.sv
package ep_ctl_txbuf_pkg;
  typedef struct packed {
    logic wrAccept;
    logic pop;
    logic advancePkt;
    logic rewind;
    logic clearAll;
  } txStrobes_t;
endpackage

// File: rtl/ep_ctl_txbuf_ctrl.sv
module ep_ctl_txbuf_ctrl
  import ep_ctl_txbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic       cpuSetRdy,
  input  logic       contMode,
  input  logic       txPop,
  input  logic       pktDone,
  input  logic       pktFail,
  input  logic       lastPkt,
  output logic       inRdy,
  output txStrobes_t strobes
);
  logic doneOk;
  logic finish;

  always_comb begin
    doneOk             = inRdy & pktDone & ~pktFail;
    finish             = doneOk & (~contMode | lastPkt);
    strobes.wrAccept   = cpuWrEn & ~inRdy;
    strobes.rewind     = inRdy & pktFail;
    strobes.clearAll   = finish;
    strobes.advancePkt = doneOk & ~finish;
    strobes.pop        = inRdy & txPop & ~pktDone & ~pktFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRdy <= 1'b0;
    end else if (finish) begin
      inRdy <= 1'b0;
    end else if (cpuSetRdy && !inRdy) begin
      inRdy <= 1'b1;
    end
  end
endmodule

// File: rtl/ep_ctl_txbuf_dp.sv
module ep_ctl_txbuf_dp
  import ep_ctl_txbuf_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int MIN_PKT = 8,
  parameter int SEL_W   = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobes_t       strobes,
  input  logic             cpuWordMode,
  input  logic [15:0]      cpuWrData,
  input  logic             contMode,
  input  logic [SEL_W-1:0] maxPktSel,
  output logic [CNT_W-1:0] pktLen,
  output logic             lastPkt,
  output logic [7:0]       txData
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wrPtr;
  logic [CNT_W-1:0] pktStart;
  logic [CNT_W-1:0] rdPtr;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] maxPkt;
  logic [CNT_W-1:0] pktEnd;
  logic [CNT_W-1:0] wrHiIdx;
  logic [CNT_W-1:0] wrNext;

  always_comb begin
    maxPkt    = CNT_W'(MIN_PKT) << maxPktSel;
    remaining = wrPtr - pktStart;
    if (contMode && remaining > maxPkt) begin
      pktLen  = maxPkt;
      lastPkt = 1'b0;
    end else begin
      pktLen  = remaining;
      lastPkt = 1'b1;
    end
    pktEnd  = pktStart + pktLen;
    wrHiIdx = wrPtr + CNT_W'(1);
    wrNext  = wrPtr + (cpuWordMode ? CNT_W'(2) : CNT_W'(1));
    if (wrNext > DEPTH_C) wrNext = DEPTH_C;
    txData  = mem[rdPtr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (strobes.wrAccept) begin
      if (wrPtr < DEPTH_C) mem[wrPtr[ADDR_W-1:0]] <= cpuWrData[7:0];
      if (cpuWordMode && wrHiIdx < DEPTH_C) mem[wrHiIdx[ADDR_W-1:0]] <= cpuWrData[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      wrPtr    <= '0;
      pktStart <= '0;
      rdPtr    <= '0;
    end else begin
      if (strobes.wrAccept) wrPtr <= wrNext;
      if (strobes.advancePkt) begin
        pktStart <= pktEnd;
        rdPtr    <= pktEnd;
      end else if (strobes.rewind) begin
        rdPtr <= pktStart;
      end else if (strobes.pop && rdPtr < pktEnd) begin
        rdPtr <= rdPtr + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ep_ctl_txbuf.sv
module ep_ctl_txbuf
  import ep_ctl_txbuf_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int MIN_PKT = 8,
  parameter int SEL_W   = 2,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic             cpuWordMode,
  input  logic [15:0]      cpuWrData,
  input  logic             cpuSetRdy,
  input  logic             contMode,
  input  logic [SEL_W-1:0] maxPktSel,
  output logic             inRdy,
  output logic [CNT_W-1:0] pktLen,
  output logic [7:0]       txData,
  input  logic             txPop,
  input  logic             pktDone,
  input  logic             pktFail
);
  txStrobes_t strobes;
  logic       lastPkt;

  ep_ctl_txbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuSetRdy(cpuSetRdy),
    .contMode(contMode), .txPop(txPop), .pktDone(pktDone), .pktFail(pktFail),
    .lastPkt(lastPkt), .inRdy(inRdy), .strobes(strobes)
  );

  ep_ctl_txbuf_dp #(.DEPTH(DEPTH), .MIN_PKT(MIN_PKT), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuWordMode(cpuWordMode),
    .cpuWrData(cpuWrData), .contMode(contMode), .maxPktSel(maxPktSel),
    .pktLen(pktLen), .lastPkt(lastPkt), .txData(txData)
  );
endmodule

// File: rtl/ep_ctl_txbuf_chk.sv
module ep_ctl_txbuf_chk #(
  parameter int MIN_PKT = 8,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuSetRdy,
  input logic             contMode,
  input logic [SEL_W-1:0] maxPktSel,
  input logic             inRdy,
  input logic [CNT_W-1:0] pktLen,
  input logic             pktDone,
  input logic             pktFail
);
  logic [CNT_W-1:0] maxPkt;
  assign maxPkt = CNT_W'(MIN_PKT) << maxPktSel;

  assert_reset_idle_R1: assert property (@(posedge clk) !rstN |=> !inRdy);

  assert_set_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!inRdy && cpuSetRdy) |=> inRdy);

  assert_hold_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inRdy && !pktDone) |=> inRdy);

  assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inRdy && !contMode && pktDone && !pktFail) |=> !inRdy);

  assert_len_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inRdy && contMode) |-> (pktLen <= maxPkt));

  assert_fail_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inRdy && pktFail) |=> (inRdy && pktLen == $past(pktLen)));

  assert_count_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inRdy) |-> (pktLen == '0));
endmodule

bind ep_ctl_txbuf ep_ctl_txbuf_chk #(.MIN_PKT(MIN_PKT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuSetRdy(cpuSetRdy), .contMode(contMode),
  .maxPktSel(maxPktSel), .inRdy(inRdy), .pktLen(pktLen),
  .pktDone(pktDone), .pktFail(pktFail)
);

// File: tb/ep_ctl_txbuf_tb.sv
module ep_ctl_txbuf_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0, cpuWordMode = 1'b0, cpuSetRdy = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic        contMode = 1'b0;
  logic [1:0]  maxPktSel = '0;
  logic        inRdy;
  logic [7:0]  pktLen;
  logic [7:0]  txData;
  logic        txPop = 1'b0, pktDone = 1'b0, pktFail = 1'b0;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  ep_ctl_txbuf u_dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWordMode(cpuWordMode),
    .cpuWrData(cpuWrData), .cpuSetRdy(cpuSetRdy), .contMode(contMode),
    .maxPktSel(maxPktSel), .inRdy(inRdy), .pktLen(pktLen), .txData(txData),
    .txPop(txPop), .pktDone(pktDone), .pktFail(pktFail)
  );

  typedef struct packed {
    logic       cont;
    logic [1:0] sel;
    logic       word;
    logic [7:0] n;
    logic [7:0] base;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 8'd5,   8'h11},
    '{1'b1, 2'd0, 1'b0, 8'd20,  8'h22},
    '{1'b1, 2'd1, 1'b1, 8'd32,  8'h33},
    '{1'b1, 2'd3, 1'b1, 8'd100, 8'h44},
    '{1'b1, 2'd2, 1'b0, 8'd128, 8'h55},
    '{1'b0, 2'd3, 1'b1, 8'd11,  8'h66},
    '{1'b1, 2'd0, 1'b0, 8'd0,   8'h77},
    '{1'b1, 2'd3, 1'b1, 8'd140, 8'h88}
  };

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return 8'(base + i * 37);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wrByte(input logic [7:0] b);
    cpuWrEn = 1'b1; cpuWordMode = 1'b0; cpuWrData = {8'h00, b};
    cyc(); cpuWrEn = 1'b0;
  endtask

  task automatic wrWord(input logic [15:0] w);
    cpuWrEn = 1'b1; cpuWordMode = 1'b1; cpuWrData = w;
    cyc(); cpuWrEn = 1'b0; cpuWordMode = 1'b0;
  endtask

  task automatic setRdy();
    cpuSetRdy = 1'b1; cyc(); cpuSetRdy = 1'b0;
  endtask

  task automatic pulseDone();
    pktDone = 1'b1; cyc(); pktDone = 1'b0;
  endtask

  task automatic pulseFail();
    pktFail = 1'b1; cyc(); pktFail = 1'b0;
  endtask

  task automatic load(input logic [7:0] base, input int n, input bit word);
    int i = 0;
    while (i < n) begin
      if (word && i + 1 < n) begin
        wrWord({pat(base, i + 1), pat(base, i)});
        i += 2;
      end else begin
        wrByte(pat(base, i));
        i += 1;
      end
    end
  endtask

  // pops cnt bytes starting at index first, checking each one
  task automatic popCheck(input logic [7:0] base, input int first, input int cnt, input string req);
    for (int k = 0; k < cnt; k++) begin
      check(txData == pat(base, first + k), req, txData, pat(base, first + k));
      txPop = 1'b1; cyc(); txPop = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    check(inRdy == 1'b0, "R1 inRdy", inRdy, 0);
    check(pktLen == 8'd0, "R1 pktLen", pktLen, 0);
    rstN = 1'b1;
    cyc();

    // table walk: R2 R3 R5 R6 R7 R8 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      int total, off, mp, expLen;
      contMode  = VECS[v].cont;
      maxPktSel = VECS[v].sel;
      total = (int'(VECS[v].n) > 128) ? 128 : int'(VECS[v].n);
      mp = 8 << VECS[v].sel;
      load(VECS[v].base, VECS[v].n, VECS[v].word);
      setRdy();
      check(inRdy == 1'b1, "R3 set ready", inRdy, 1);
      off = 0;
      forever begin
        if (VECS[v].cont) expLen = (total - off > mp) ? mp : total - off;
        else expLen = total;
        check(pktLen == 8'(expLen), VECS[v].cont ? "R6 packet length" : "R5 whole length",
              pktLen, expLen);
        popCheck(VECS[v].base, off, expLen, "R2 R11 R12 byte order");
        pulseDone();
        off += expLen;
        if (off < total) begin
          check(inRdy == 1'b1, "R7 ready held mid-set", inRdy, 1);
        end else begin
          check(inRdy == 1'b0, total == 0 ? "R8 zero-length clears" : "R7 ready cleared",
                inRdy, 0);
          check(pktLen == 8'd0, "R10 count reset", pktLen, 0);
          break;
        end
      end
    end

    // R4 writes and set-ready ignored while ready
    contMode = 1'b0;
    load(8'h90, 3, 1'b0);
    setRdy();
    wrByte(8'hEE);
    wrWord(16'hABCD);
    setRdy();
    check(pktLen == 8'd3, "R4 length unchanged", pktLen, 3);
    check(inRdy == 1'b1, "R4 ready kept", inRdy, 1);
    popCheck(8'h90, 0, 3, "R4 data unchanged");
    pulseDone();
    wrByte(8'h5A);
    check(inRdy == 1'b0, "R4 still idle after write", inRdy, 0);
    check(pktLen == 8'd1, "R10 next load from zero", pktLen, 1);
    setRdy();
    check(txData == 8'h5A, "R10 first byte at offset 0", txData, 8'h5A);
    pulseDone();

    // R9 failure rewinds the current packet
    contMode = 1'b1; maxPktSel = 2'd0;
    load(8'hA1, 12, 1'b0);
    setRdy();
    popCheck(8'hA1, 0, 3, "R12 partial pop");
    pulseFail();
    check(inRdy == 1'b1, "R9 ready kept", inRdy, 1);
    check(pktLen == 8'd8, "R9 length kept", pktLen, 8);
    check(txData == pat(8'hA1, 0), "R9 rewind first packet", txData, pat(8'hA1, 0));
    popCheck(8'hA1, 0, 8, "R9 resend");
    pulseDone();
    check(pktLen == 8'd4, "R6 short final", pktLen, 4);
    popCheck(8'hA1, 8, 2, "R12 second packet");
    pktFail = 1'b1; pktDone = 1'b1; cyc(); pktFail = 1'b0; pktDone = 1'b0;
    check(inRdy == 1'b1, "R9 fail wins over done", inRdy, 1);
    check(txData == pat(8'hA1, 8), "R9 rewind second packet", txData, pat(8'hA1, 8));
    popCheck(8'hA1, 8, 4, "R9 resend short");
    txPop = 1'b1; cyc(); cyc(); txPop = 1'b0;
    check(pktLen == 8'd4, "R12 pop past end length", pktLen, 4);
    pulseDone();
    check(inRdy == 1'b0, "R7 done after retry", inRdy, 0);

    // R8 zero-length packet in single mode
    contMode = 1'b0;
    setRdy();
    check(pktLen == 8'd0, "R8 zero length", pktLen, 0);
    pulseDone();
    check(inRdy == 1'b0, "R8 cleared", inRdy, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule